// File: doc/BRIEF.md
# Handshaked DMA transfer engine

This block is the sequencer and datapath behind a four-channel DMA controller. A separate register block holds each channel's control word, source address, destination address and element count. When a channel's start bit is set, the engine takes the channel, copies its settings into working registers, and moves data in bursts. Each element is read and then written through a single-beat memory master port. After the work is done, or when the channel has to wait, the engine writes the updated addresses and count back through a one-cycle writeback strobe.

Elements are 8, 16 or 32 bits wide. A burst moves one element or four. Each address either stays fixed or increments by one, two or four element sizes per element. Each channel names one of sixteen peripheral request lines for its source side and one for its destination side. A burst starts only when both named lines are high. The engine raises the matching acknowledge line after the read phase of the burst and again after the write phase. Active channels are visited in ascending index order, and only one channel owns the memory port at a time.

Top module: `dma_hs_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_req`, `busy_valid`, `wb_valid` and every `ack_out` bit are low.
- R2: Channels whose start bit (control bit 0) is set are served in passes of ascending index, and each channel keeps the memory port until it finishes or stalls. During every memory access, `busy_valid` is high and `busy_ch` names the owning channel.
- R3: The source handshake ID is in control bits 27:24 and the destination ID is in bits 19:16, and ID 0 means no handshake. Before each burst, if a nonzero ID's `req_in` line is low, the channel stalls. A stall moves no data, issues a writeback with `wb_stop` low and the count unchanged, and leaves the start bit set so the channel is retried.
- R4: One cycle after the last read of a burst, `ack_out` of the nonzero source ID is high. One cycle after the last write of a burst, `ack_out` of the nonzero destination ID is high.
- R5: An `ack_out` bit is low in any cycle that follows a cycle in which its `req_in` bit was low.
- R6: The width code in control bits 21:20 selects 32-bit elements for 0, 16-bit for 1, and 8-bit for 2 or 3. Byte lanes come from the low address bits, little-endian: `mem_be` is 4'hF for 32-bit, 4'h3 or 4'hC by address bit 1 for 16-bit, and 1<<addr[1:0] for 8-bit. Write data carries the element replicated across all lanes.
- R7: Control bit 3 selects bursts of four elements, otherwise bursts of one. When fewer elements remain than the burst size, the last burst moves only the remainder, and the count drops by the number of elements moved.
- R8: The source step code is in bits 9:8 and the destination step code in bits 13:12. Code 0 keeps the address fixed; codes 1, 2 and 3 advance it by 1, 2 and 4 element sizes after each element.
- R9: When the count is zero, either after the last burst or at the start, the engine issues a writeback with `wb_stop` high and `wb_count` zero. `wb_done` is high in that writeback only if the done enable (control bit 2) is set.
- R10: Every writeback, whether it ends the channel or records a stall, carries the channel's current source and destination addresses and remaining count.
- R11: A memory access holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until the cycle in which `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_ctrl | input | NCH*32 | Control word of each channel (start, done enable, burst, steps, width, handshake IDs) |
| ch_src | input | NCH*AW | Source address of each channel |
| ch_dst | input | NCH*AW | Destination address of each channel |
| ch_count | input | NCH*CW | Remaining element count of each channel |
| busy_valid | output | 1 | A channel owns the engine |
| busy_ch | output | IW | Index of the owning channel |
| wb_valid | output | 1 | One-cycle writeback strobe |
| wb_ch | output | IW | Channel the writeback belongs to |
| wb_src | output | AW | Updated source address |
| wb_dst | output | AW | Updated destination address |
| wb_count | output | CW | Updated remaining count |
| wb_stop | output | 1 | Clear the channel's start bit |
| wb_done | output | 1 | Set the channel's done flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address |
| mem_be | output | 4 | Byte enables of a write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_ready | input | 1 | Access completes this cycle |
| req_in | input | 16 | Peripheral request lines |
| ack_out | output | 16 | Peripheral acknowledge lines |

## Verification
The hardest situation to reach is a channel that is partly ready. Its source request is high and its destination request is still low, so the channel has to keep stalling and rescanning without moving data and without raising any acknowledge. The bench starts a handshaked channel with both request lines low, then raises only the source line. It watches that the writebacks leave the count and addresses unchanged and that no write appears, and only then raises the destination line and queues the expected writes. Ready stalls on the memory port are mixed in throughout, so address hold and lane selection are checked under backpressure.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

  localparam int unsigned CTRL_W    = 32;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned BE_W      = DATA_W / 8;
  localparam int unsigned HS_ID_W   = 4;
  localparam int unsigned BURST_MAX = 4;

  // control word field positions, shared with the register block
  localparam int unsigned START_BIT   = 0;
  localparam int unsigned DONE_EN_BIT = 2;
  localparam int unsigned BURST_BIT   = 3;
  localparam int unsigned SSTEP_LO    = 8;
  localparam int unsigned DSTEP_LO    = 12;
  localparam int unsigned DHS_LO      = 16;
  localparam int unsigned WID_LO      = 20;
  localparam int unsigned SHS_LO      = 24;

  typedef enum logic [2:0] {
    ST_SCAN,
    ST_GATE,
    ST_READ,
    ST_WRITE,
    ST_WB
  } seq_state_t;

  typedef struct packed {
    logic               done_en;
    logic               burst4;
    logic [1:0]         sstep;
    logic [1:0]         dstep;
    logic [1:0]         wcode;
    logic [HS_ID_W-1:0] shs;
    logic [HS_ID_W-1:0] dhs;
  } chan_cfg_t;

  function automatic chan_cfg_t decode_cfg(input logic [CTRL_W-1:0] w);
    chan_cfg_t c;
    c.done_en = w[DONE_EN_BIT];
    c.burst4  = w[BURST_BIT];
    c.sstep   = w[SSTEP_LO +: 2];
    c.dstep   = w[DSTEP_LO +: 2];
    c.wcode   = w[WID_LO +: 2];
    c.shs     = w[SHS_LO +: HS_ID_W];
    c.dhs     = w[DHS_LO +: HS_ID_W];
    return c;
  endfunction

  function automatic logic [2:0] elem_bytes(input logic [1:0] wcode);
    case (wcode)
      2'd0:    return 3'd4;
      2'd1:    return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [4:0] step_bytes(input logic [1:0] code, input logic [2:0] eb);
    case (code)
      2'd0:    return 5'd0;
      2'd1:    return {2'b00, eb};
      2'd2:    return {1'b0, eb, 1'b0};
      default: return {eb, 2'b00};
    endcase
  endfunction

endpackage

// File: rtl/dma_hs_scan.sv
module dma_hs_scan #(
  parameter  int NCH = 4,
  localparam int IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] active,
  input  logic [IW-1:0]  base,
  output logic           hit,
  output logic [IW-1:0]  pick
);

  // lowest active channel at or above the pass pointer
  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (active[i] && (i >= int'(base))) begin
        hit  = 1'b1;
        pick = IW'(i);
      end
    end
  end

endmodule

// File: rtl/dma_hs_lane.sv
module dma_hs_lane
  import dma_hs_pkg::*;
(
  input  logic [1:0]        wcode,
  input  logic [1:0]        addr_lo,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] elem,
  output logic [DATA_W-1:0] rd_elem,
  output logic [DATA_W-1:0] wdata,
  output logic [BE_W-1:0]   be
);

  logic [DATA_W-1:0] shifted;

  always_comb begin
    shifted = rdata >> {addr_lo, 3'b000};
    case (wcode)
      2'd0: begin
        rd_elem = rdata;
        wdata   = elem;
        be      = '1;
      end
      2'd1: begin
        rd_elem = {16'h0, shifted[15:0]};
        wdata   = {2{elem[15:0]}};
        be      = addr_lo[1] ? 4'hC : 4'h3;
      end
      default: begin
        rd_elem = {24'h0, shifted[7:0]};
        wdata   = {4{elem[7:0]}};
        be      = 4'b0001 << addr_lo;
      end
    endcase
  end

endmodule

// File: rtl/dma_hs_ack.sv
module dma_hs_ack
  import dma_hs_pkg::*;
#(
  localparam int NREQ = 1 << HS_ID_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREQ-1:0]    req_in,
  input  logic               set_src,
  input  logic [HS_ID_W-1:0] src_id,
  input  logic               set_dst,
  input  logic [HS_ID_W-1:0] dst_id,
  output logic [NREQ-1:0]    ack_out
);

  logic [NREQ-1:0] ack_q, ack_d, set_vec;

  always_comb begin
    set_vec = '0;
    if (set_src) set_vec[src_id] = 1'b1;
    if (set_dst) set_vec[dst_id] = 1'b1;
    // a low request line always wins over a new acknowledge
    ack_d = (ack_q | set_vec) & req_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= '0;
    else        ack_q <= ack_d;
  end

  assign ack_out = ack_q;

endmodule

// File: rtl/dma_hs_engine.sv
module dma_hs_engine
  import dma_hs_pkg::*;
#(
  parameter  int NCH  = 4,
  parameter  int AW   = 32,
  parameter  int CW   = 24,
  localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int NREQ = 1 << HS_ID_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH*32-1:0]   ch_ctrl,
  input  logic [NCH*AW-1:0]   ch_src,
  input  logic [NCH*AW-1:0]   ch_dst,
  input  logic [NCH*CW-1:0]   ch_count,
  output logic                busy_valid,
  output logic [IW-1:0]       busy_ch,
  output logic                wb_valid,
  output logic [IW-1:0]       wb_ch,
  output logic [AW-1:0]       wb_src,
  output logic [AW-1:0]       wb_dst,
  output logic [CW-1:0]       wb_count,
  output logic                wb_stop,
  output logic                wb_done,
  output logic                mem_req,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [3:0]          mem_be,
  output logic [31:0]         mem_wdata,
  input  logic [31:0]         mem_rdata,
  input  logic                mem_ready,
  input  logic [NREQ-1:0]     req_in,
  output logic [NREQ-1:0]     ack_out
);

  localparam int BIW = $clog2(BURST_MAX);
  localparam int BCW = BIW + 1;

  seq_state_t        state_q, state_d;
  logic [IW-1:0]     ch_q, ch_d, ptr_q, ptr_d;
  logic [AW-1:0]     src_q, src_d, dst_q, dst_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  chan_cfg_t         cfg_q, cfg_d;
  logic [BIW-1:0]    idx_q, idx_d;
  logic [BCW-1:0]    beats_q, beats_d;
  logic              fin_q, fin_d;
  logic [DATA_W-1:0] buf_q [BURST_MAX];
  logic              buf_we;
  logic              src_ack, dst_ack;

  // start bits of all channels
  logic [NCH-1:0] active;
  for (genvar g = 0; g < NCH; g++) begin : g_start
    assign active[g] = ch_ctrl[g*32 + START_BIT];
  end

  logic          hit;
  logic [IW-1:0] pick;

  dma_hs_scan #(.NCH(NCH)) u_scan (
    .active (active),
    .base   (ptr_q),
    .hit    (hit),
    .pick   (pick)
  );

  logic [31:0] pick_ctrl;
  logic        ctrl_unused;
  assign pick_ctrl   = ch_ctrl[pick*32 +: 32];
  assign ctrl_unused = ^{pick_ctrl[31:28], pick_ctrl[23:22], pick_ctrl[15:14],
                         pick_ctrl[11:10], pick_ctrl[7:4], pick_ctrl[1:0], mem_addr[AW-1:2]};

  logic [2:0] ebytes;
  logic [4:0] sstep_b, dstep_b;
  logic       src_hs_ok, dst_hs_ok, last_beat;

  always_comb begin
    ebytes    = elem_bytes(cfg_q.wcode);
    sstep_b   = step_bytes(cfg_q.sstep, ebytes);
    dstep_b   = step_bytes(cfg_q.dstep, ebytes);
    src_hs_ok = (cfg_q.shs == '0) || req_in[cfg_q.shs];
    dst_hs_ok = (cfg_q.dhs == '0) || req_in[cfg_q.dhs];
    last_beat = ({1'b0, idx_q} == (beats_q - BCW'(1)));
  end

  logic [DATA_W-1:0] rd_elem;

  dma_hs_lane u_lane (
    .wcode   (cfg_q.wcode),
    .addr_lo (mem_addr[1:0]),
    .rdata   (mem_rdata),
    .elem    (buf_q[idx_q]),
    .rd_elem (rd_elem),
    .wdata   (mem_wdata),
    .be      (mem_be)
  );

  dma_hs_ack u_ack (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_in  (req_in),
    .set_src (src_ack),
    .src_id  (cfg_q.shs),
    .set_dst (dst_ack),
    .dst_id  (cfg_q.dhs),
    .ack_out (ack_out)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    ptr_d   = ptr_q;
    src_d   = src_q;
    dst_d   = dst_q;
    cnt_d   = cnt_q;
    cfg_d   = cfg_q;
    idx_d   = idx_q;
    beats_d = beats_q;
    fin_d   = fin_q;
    buf_we  = 1'b0;
    src_ack = 1'b0;
    dst_ack = 1'b0;
    case (state_q)
      ST_SCAN: begin
        if (hit) begin
          ch_d    = pick;
          cfg_d   = decode_cfg(pick_ctrl);
          src_d   = ch_src[pick*AW +: AW];
          dst_d   = ch_dst[pick*AW +: AW];
          cnt_d   = ch_count[pick*CW +: CW];
          state_d = ST_GATE;
        end else begin
          ptr_d = '0;
        end
      end
      ST_GATE: begin
        if (cnt_q == '0) begin
          fin_d   = 1'b1;
          state_d = ST_WB;
        end else if (!(src_hs_ok && dst_hs_ok)) begin
          fin_d   = 1'b0;
          state_d = ST_WB;
        end else begin
          if (!cfg_q.burst4)                   beats_d = BCW'(1);
          else if (cnt_q >= CW'(BURST_MAX))    beats_d = BCW'(BURST_MAX);
          else                                 beats_d = cnt_q[BCW-1:0];
          idx_d   = '0;
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        if (mem_ready) begin
          buf_we = 1'b1;
          src_d  = src_q + AW'(sstep_b);
          if (last_beat) begin
            idx_d   = '0;
            src_ack = (cfg_q.shs != '0);
            state_d = ST_WRITE;
          end else begin
            idx_d = idx_q + BIW'(1);
          end
        end
      end
      ST_WRITE: begin
        if (mem_ready) begin
          dst_d = dst_q + AW'(dstep_b);
          if (last_beat) begin
            idx_d   = '0;
            cnt_d   = cnt_q - CW'(beats_q);
            dst_ack = (cfg_q.dhs != '0);
            state_d = ST_GATE;
          end else begin
            idx_d = idx_q + BIW'(1);
          end
        end
      end
      default: begin
        ptr_d   = (ch_q == IW'(NCH - 1)) ? '0 : ch_q + IW'(1);
        state_d = ST_SCAN;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SCAN;
      ch_q    <= '0;
      ptr_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      cfg_q   <= '0;
      idx_q   <= '0;
      beats_q <= '0;
      fin_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      ptr_q   <= ptr_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      cnt_q   <= cnt_d;
      cfg_q   <= cfg_d;
      idx_q   <= idx_d;
      beats_q <= beats_d;
      fin_q   <= fin_d;
    end
  end

  // burst buffer, one enabled register per element slot
  for (genvar b = 0; b < BURST_MAX; b++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   buf_q[b] <= '0;
      else if (buf_we && (idx_q == BIW'(b)))        buf_q[b] <= rd_elem;
    end
  end

  assign busy_valid = (state_q != ST_SCAN);
  assign busy_ch    = ch_q;
  assign mem_req    = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we     = (state_q == ST_WRITE);
  assign mem_addr   = mem_we ? dst_q : src_q;
  assign wb_valid   = (state_q == ST_WB);
  assign wb_ch      = ch_q;
  assign wb_src     = src_q;
  assign wb_dst     = dst_q;
  assign wb_count   = cnt_q;
  assign wb_stop    = wb_valid && fin_q;
  assign wb_done    = wb_valid && fin_q && cfg_q.done_en;

endmodule

// File: rtl/dma_hs_engine_chk.sv
module dma_hs_engine_chk
  import dma_hs_pkg::*;
#(
  parameter  int NCH  = 4,
  parameter  int AW   = 32,
  parameter  int CW   = 24,
  localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int NREQ = 1 << HS_ID_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH*32-1:0] ch_ctrl,
  input logic [NCH*AW-1:0] ch_src,
  input logic [NCH*AW-1:0] ch_dst,
  input logic [NCH*CW-1:0] ch_count,
  input logic              busy_valid,
  input logic [IW-1:0]     busy_ch,
  input logic              wb_valid,
  input logic [IW-1:0]     wb_ch,
  input logic [AW-1:0]     wb_src,
  input logic [AW-1:0]     wb_dst,
  input logic [CW-1:0]     wb_count,
  input logic              wb_stop,
  input logic              wb_done,
  input logic              mem_req,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic [3:0]        mem_be,
  input logic [31:0]       mem_wdata,
  input logic [31:0]       mem_rdata,
  input logic              mem_ready,
  input logic [NREQ-1:0]   req_in,
  input logic [NREQ-1:0]   ack_out
);

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  // R2
  owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy_valid);

  // R5
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ack_out & ~$past(req_in)) == '0));

  // R6
  lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (($countones(mem_be) == 1) || ($countones(mem_be) == 2) || ($countones(mem_be) == 4)));

  // R9
  done_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |-> (wb_valid && wb_stop && ch_ctrl[32*wb_ch + DONE_EN_BIT]));

  // R9
  stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stop |-> (wb_count == '0));

endmodule

bind dma_hs_engine dma_hs_engine_chk #(.NCH(NCH), .AW(AW), .CW(CW)) u_chk (.*);

// File: tb/tb_dma_hs_engine.sv
`timescale 1ns/1ps
module tb_dma_hs_engine;

  localparam int NCH = 4;
  localparam int AW  = 32;
  localparam int CW  = 24;
  localparam int IW  = 2;

  logic              clk, rst_n;
  logic [NCH*32-1:0] ch_ctrl;
  logic [NCH*AW-1:0] ch_src, ch_dst;
  logic [NCH*CW-1:0] ch_count;
  logic              busy_valid, wb_valid, wb_stop, wb_done;
  logic [IW-1:0]     busy_ch, wb_ch;
  logic [AW-1:0]     wb_src, wb_dst, mem_addr;
  logic [CW-1:0]     wb_count;
  logic              mem_req, mem_we, mem_ready;
  logic [3:0]        mem_be;
  logic [31:0]       mem_wdata, mem_rdata;
  logic [15:0]       req_in, ack_out;

  dma_hs_engine #(.NCH(NCH), .AW(AW), .CW(CW)) dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // register block model
  logic [31:0] r_ctrl [NCH];
  logic [31:0] r_src [NCH], r_dst [NCH];
  logic [23:0] r_cnt [NCH];
  logic [31:0] s_ctrl [NCH];
  logic [31:0] s_src [NCH], s_dst [NCH];
  logic [23:0] s_cnt [NCH];
  logic [NCH-1:0] cpu_mask;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      ch_ctrl[i*32 +: 32] = r_ctrl[i];
      ch_src[i*AW +: AW]  = r_src[i];
      ch_dst[i*AW +: AW]  = r_dst[i];
      ch_count[i*CW +: CW] = r_cnt[i];
    end
  end

  always @(posedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (!rst_n) begin
        r_ctrl[i] <= '0; r_src[i] <= '0; r_dst[i] <= '0; r_cnt[i] <= '0;
      end else if (cpu_mask[i]) begin
        r_ctrl[i] <= s_ctrl[i]; r_src[i] <= s_src[i];
        r_dst[i] <= s_dst[i];   r_cnt[i] <= s_cnt[i];
      end else if (wb_valid && wb_ch == IW'(i)) begin
        r_src[i] <= wb_src; r_dst[i] <= wb_dst; r_cnt[i] <= wb_count;
        if (wb_stop) r_ctrl[i][0] <= 1'b0;
        if (wb_done) r_ctrl[i][1] <= 1'b1;
      end
    end
  end

  // memory model with periodic ready stalls
  logic [7:0] mem [1024];
  logic [9:0] wa;
  assign wa = {mem_addr[9:2], 2'b00};
  assign mem_rdata = {mem[wa+3], mem[wa+2], mem[wa+1], mem[wa]};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= rst_n && ((cyc % 3) != 0);
    if (mem_req && mem_we && mem_ready)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[wa + 10'(b)] <= mem_wdata[b*8 +: 8];
  end

  // scoreboard
  typedef struct { int ch; logic [31:0] addr; logic [3:0] be; logic [31:0] data; } exp_t;
  exp_t q[$];

  function automatic logic [31:0] mk_ctrl(bit st, bit den, bit b4, logic [1:0] ss, logic [1:0] ds,
                                          logic [1:0] w, logic [3:0] shs, logic [3:0] dhs);
    return {4'h0, shs, 2'b00, w, dhs, 2'b00, ds, 2'b00, ss, 4'h0, b4, den, 1'b0, st};
  endfunction

  function automatic int ebytes(logic [1:0] w);
    return (w == 0) ? 4 : (w == 1) ? 2 : 1;
  endfunction

  function automatic int stepb(logic [1:0] c, int eb);
    return (c == 0) ? 0 : (c == 1) ? eb : (c == 2) ? 2*eb : 4*eb;
  endfunction

  // driver: expected writes of one channel, computed from memory contents
  task automatic push_exp(int ch, logic [31:0] ctrl, logic [31:0] src, logic [31:0] dst, int cnt);
    int eb, ss, ds;
    eb = ebytes(ctrl[21:20]);
    ss = stepb(ctrl[9:8], eb);
    ds = stepb(ctrl[13:12], eb);
    for (int i = 0; i < cnt; i++) begin
      exp_t e;
      logic [9:0] sa;
      logic [31:0] da;
      sa = 10'(src + 32'(i*ss));
      da = dst + 32'(i*ds);
      e.ch = ch; e.addr = da;
      if (eb == 4) begin
        e.data = {mem[sa+3], mem[sa+2], mem[sa+1], mem[sa]}; e.be = 4'hF;
      end else if (eb == 2) begin
        e.data = {2{mem[sa+1], mem[sa]}}; e.be = da[1] ? 4'hC : 4'h3;
      end else begin
        e.data = {4{mem[sa]}}; e.be = 4'b0001 << da[1:0];
      end
      q.push_back(e);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we && mem_ready) begin
      if (q.size() == 0) begin
        chk(1'b0, "R3", "unexpected write addr", mem_addr, 32'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(mem_addr == e.addr, "R8", "write address", mem_addr, e.addr);
        chk(mem_be == e.be && mem_wdata == e.data, "R6", "write lanes/data", mem_wdata, e.data);
        chk(busy_valid && busy_ch == IW'(e.ch), "R2", "owner during write", 32'(busy_ch), 32'(e.ch));
        if (e.ch == 3) chk(ack_out[5], "R4", "source ack before write phase", 32'(ack_out), 32'h20);
      end
    end
  end

  task automatic stage(int ch, logic [31:0] ctrl, logic [31:0] src, logic [31:0] dst, logic [23:0] cnt);
    s_ctrl[ch] = ctrl; s_src[ch] = src; s_dst[ch] = dst; s_cnt[ch] = cnt;
  endtask

  task automatic commit(logic [NCH-1:0] m);
    @(negedge clk); cpu_mask = m;
    @(negedge clk); cpu_mask = '0;
  endtask

  task automatic wait_stop(int ch);
    int n = 0;
    while (r_ctrl[ch][0] && n < 3000) begin @(negedge clk); n++; end
    chk(!r_ctrl[ch][0], "R9", "start bit cleared", r_ctrl[ch], 32'h0);
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_final(int ch, string rq, logic [31:0] s, logic [31:0] d, bit done);
    chk(r_src[ch] == s, "R10", "final source", r_src[ch], s);
    chk(r_dst[ch] == d, "R10", "final destination", r_dst[ch], d);
    chk(r_cnt[ch] == 0, "R9", "final count", 32'(r_cnt[ch]), 0);
    chk(r_ctrl[ch][1] == done, rq, "done flag", 32'(r_ctrl[ch][1]), 32'(done));
    chk(q.size() == 0, "R7", "scoreboard drained", q.size(), 0);
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    chk(1'b0, "R2", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] c0, c1, c2, c3;
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i*7 + 3);
    cpu_mask = '0; req_in = '0; rst_n = 1'b0;
    for (int i = 0; i < NCH; i++) stage(i, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(!mem_req && !busy_valid && !wb_valid && ack_out == 0, "R1", "reset outputs", 32'(ack_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !busy_valid && !wb_valid && ack_out == 0, "R1", "after reset", 32'(mem_req), 0);

    // R7 single-element bursts, 32-bit, incrementing
    c0 = mk_ctrl(1, 1, 0, 1, 1, 0, 0, 0);
    push_exp(0, c0, 32'h000, 32'h200, 3);
    stage(0, c0, 32'h000, 32'h200, 3); commit(4'b0001);
    wait_stop(0);
    chk_final(0, "R9", 32'h00C, 32'h20C, 1);

    // R2 two channels started together, lower index first; partial burst R7
    c1 = mk_ctrl(1, 1, 1, 1, 1, 2, 0, 0);
    c2 = mk_ctrl(1, 0, 1, 0, 3, 1, 0, 0);
    push_exp(1, c1, 32'h041, 32'h281, 6);
    push_exp(2, c2, 32'h062, 32'h300, 4);
    stage(1, c1, 32'h041, 32'h281, 6);
    stage(2, c2, 32'h062, 32'h300, 4);
    commit(4'b0110);
    wait_stop(1); wait_stop(2);
    chk_final(1, "R9", 32'h047, 32'h287, 1);
    chk_final(2, "R9", 32'h062, 32'h320, 0);

    // R9 zero count completes at once
    stage(0, mk_ctrl(1, 1, 0, 1, 1, 0, 0, 0), 32'h010, 32'h210, 0); commit(4'b0001);
    wait_stop(0);
    chk_final(0, "R9", 32'h010, 32'h210, 1);

    // R3 handshake stall: source id 5, destination id 9
    c3 = mk_ctrl(1, 1, 1, 2, 1, 0, 4'd5, 4'd9);
    stage(3, c3, 32'h080, 32'h380, 5); commit(4'b1000);
    repeat (30) @(negedge clk);
    chk(r_ctrl[3][0] && r_cnt[3] == 5 && r_src[3] == 32'h80, "R3", "stall keeps channel", 32'(r_cnt[3]), 5);
    chk(ack_out == 0, "R3", "no ack while stalled", 32'(ack_out), 0);
    req_in[5] = 1'b1;
    repeat (30) @(negedge clk);
    chk(r_ctrl[3][0] && r_cnt[3] == 5 && r_dst[3] == 32'h380, "R10", "half-ready stall writeback", r_dst[3], 32'h380);
    chk(ack_out == 0, "R3", "no ack with destination low", 32'(ack_out), 0);
    push_exp(3, c3, 32'h080, 32'h380, 5);
    req_in[9] = 1'b1;
    wait_stop(3);
    chk_final(3, "R9", 32'h0A8, 32'h394, 1);
    chk(ack_out[5] && ack_out[9], "R4", "both acks raised", 32'(ack_out), 32'h220);
    req_in[5] = 1'b0;
    @(negedge clk);
    chk(!ack_out[5] && ack_out[9], "R5", "ack drops with request", 32'(ack_out), 32'h200);
    req_in[9] = 1'b0;
    @(negedge clk);
    chk(ack_out == 0, "R5", "all acks dropped", 32'(ack_out), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule